// File: doc/BRIEF.md
# Transmit/Receive FIFO Pair with Sticky Event Flags

This block holds the two data queues that sit between a bus-side register port and a serial shift engine. Software writes the data register to load the transmit queue and reads it to drain the receive queue. The serial engine pops transmit entries and pushes received ones. Each access of any size moves exactly one entry. Byte and halfword accesses are zero-extended to the 32-bit entry.

Each queue has its own enable, a one-cycle clear strobe, a live entry count and a programmable level. The transmit level fires when the queue runs low. The receive level fires when the queue fills past the level. Eight sticky event flags record level crossings, empty and full states, and overruns and underruns, with each side tracked separately. A masked OR of the flags drives one interrupt line. The level conditions also drive two DMA request lines.

All four data interfaces are valid/ready. A beat moves when valid and ready are both high. The block never stalls a source or a sink. A push offered while ready is low is dropped and counts as an overrun. A pop requested (ready high) while valid is low returns zero and counts as an underrun. Sources do not have to hold a beat after rejection.

Top module: `spi_fifo_pair`

## Requirements
- R1: An accepted bus write pushes its data with size code 0 (byte) or 1 (halfword) zero-extended from the low bits, and codes 2 or 3 (word) kept whole. A bus read pops the receive head, masked to the read size code in the same way. Both queues keep first-in first-out order.
- R2: The transmit queue holds 16 entries and the receive queue holds 32. Counts run from 0 to the full depth and are zero after reset. Ready is high only when the queue is enabled and not full. Valid is high only when it is enabled and not empty.
- R3: Flag bit 0 sets while transmit is enabled and its count is below the 5-bit transmit level. `tx_dma_req` is high exactly when transmit DMA is enabled, transmit is enabled and that same condition holds.
- R4: Flag bit 1 sets while receive is enabled and its count is above the 6-bit receive level. `rx_dma_req` is high exactly when receive DMA is enabled, receive is enabled and that same condition holds.
- R5: A bus write offered to an enabled, full transmit queue sets flag bit 4 and leaves the queue contents and count unchanged.
- R6: A serial pop requested from an enabled, empty transmit queue sets flag bit 5, and the serial data output reads zero.
- R7: A serial push offered to an enabled, full receive queue sets flag bit 6 and leaves that queue unchanged.
- R8: A bus read requested from an enabled, empty receive queue sets flag bit 7, and the read data is zero.
- R9: Flag bit 2 sets while transmit is enabled and empty. Flag bit 3 sets while receive is enabled and full.
- R10: A clear strobe empties its queue at the next edge and zeroes that queue's flags (transmit: bits 0, 2, 4, 5; receive: bits 1, 3, 6, 7). Clear takes priority over any access or event in the same cycle.
- R11: A flag stays set until a 1 is written to its bit in `flag_clr`. If a new event for that bit arrives in the same cycle, the flag stays set.
- R12: `irq` is the OR over all bits of `flags` AND `irq_en`.
- R13: While a queue is disabled, accesses to it are ignored and raise no flag, and its count holds. Dropping a DMA enable removes that request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit queue enable |
| rx_en | input | 1 | Receive queue enable |
| tx_clr | input | 1 | Transmit queue clear strobe |
| rx_clr | input | 1 | Receive queue clear strobe |
| tx_level | input | 5 | Transmit low-water level |
| rx_level | input | 6 | Receive high-water level |
| tx_dma_en | input | 1 | Transmit DMA request enable |
| rx_dma_en | input | 1 | Receive DMA request enable |
| irq_en | input | 8 | Per-flag interrupt enables |
| flag_clr | input | 8 | Write-one-to-clear strobes for the flags |
| bw_valid | input | 1 | Bus write beat offered |
| bw_ready | output | 1 | Transmit queue can take a beat |
| bw_size | input | 2 | Bus write size code |
| bw_data | input | 32 | Bus write data |
| br_valid | output | 1 | Receive head available |
| br_ready | input | 1 | Bus read request (pop) |
| br_size | input | 2 | Bus read size code |
| br_data | output | 32 | Bus read data, zero when empty |
| st_valid | output | 1 | Transmit head available to serial side |
| st_ready | input | 1 | Serial side pops transmit head |
| st_data | output | 32 | Transmit head, zero when empty |
| sr_valid | input | 1 | Serial side offers a received entry |
| sr_ready | output | 1 | Receive queue can take an entry |
| sr_data | input | 32 | Received entry |
| tx_count | output | 5 | Transmit entries held |
| rx_count | output | 6 | Receive entries held |
| flags | output | 8 | Sticky event flags |
| irq | output | 1 | Masked interrupt |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The hardest state to reach is a full receive queue of 32 entries while the bus side keeps reading, with a serial push that overruns while a flag clear or queue clear arrives in the same cycle. Random stimulus runs in phases, and each phase sets its own push and pop rates. Some phases push much faster than they pop, so the receive queue fills and stays full. Clear strobes and flag writes are mixed in at low rates. Directed sequences fill both queues past the brim, drain them past empty, and check the collision of a flag write with a persisting event.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int DW     = 32;
  localparam int NFLAGS = 8;

  // flag positions
  localparam int FL_TX_LOW   = 0;
  localparam int FL_RX_HIGH  = 1;
  localparam int FL_TX_EMPTY = 2;
  localparam int FL_RX_FULL  = 3;
  localparam int FL_TX_OVR   = 4;
  localparam int FL_TX_UND   = 5;
  localparam int FL_RX_OVR   = 6;
  localparam int FL_RX_UND   = 7;

  localparam logic [NFLAGS-1:0] TX_GROUP = 8'h35;
  localparam logic [NFLAGS-1:0] RX_GROUP = 8'hCA;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD2 = 2'd3
  } acc_size_e;

  function automatic logic [DW-1:0] size_fit(input logic [DW-1:0] d, input logic [1:0] sz);
    logic [DW-1:0] r;
    case (acc_size_e'(sz))
      SZ_BYTE: r = {{(DW-8){1'b0}}, d[7:0]};
      SZ_HALF: r = {{(DW-16){1'b0}}, d[15:0]};
      default: r = d;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sfp_queue.sv
module sfp_queue #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [CW-1:0] count,
  output logic          ovr_ev,
  output logic          und_ev
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count_q;
  logic          push_ok, pop_ok;

  assign in_ready  = en && (count_q != CW'(DEPTH));
  assign out_valid = en && (count_q != '0);
  assign push_ok   = in_valid && in_ready;
  assign pop_ok    = out_ready && out_valid;
  assign out_data  = out_valid ? mem[rd_ptr] : '0;
  assign ovr_ev    = en && in_valid && !in_ready;
  assign und_ev    = en && out_ready && !out_valid;
  assign count     = count_q;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else if (clr) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr);
      if (pop_ok)  rd_ptr <= step(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));
  a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count_q == '0);
  a_r5_reject_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !(out_ready && out_valid) && !clr) |=> $stable(count_q));
  a_r13_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(count_q));
endmodule

// File: rtl/sfp_level.sv
module sfp_level #(
  parameter int CW    = 5,
  parameter int LW    = 5,
  parameter bit ABOVE = 1'b0,
  localparam int MW   = (CW > LW) ? CW : LW
) (
  input  logic          en,
  input  logic          dma_en,
  input  logic [CW-1:0] count,
  input  logic [LW-1:0] level,
  output logic          cond,
  output logic          dma_req
);
  logic [MW-1:0] c_ext, l_ext;
  assign c_ext = MW'(count);
  assign l_ext = MW'(level);

  generate
    if (ABOVE) begin : g_above
      assign cond = en && (c_ext > l_ext);
    end else begin : g_below
      assign cond = en && (c_ext < l_ext);
    end
  endgenerate

  assign dma_req = dma_en && cond;
endmodule

// File: rtl/sfp_flags.sv
module sfp_flags #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] w1c,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] irq_en,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] flags_q;

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           flags_q[i] <= 1'b0;
        else if (clr_mask[i]) flags_q[i] <= 1'b0;
        else if (set[i])      flags_q[i] <= 1'b1;
        else if (w1c[i])      flags_q[i] <= 1'b0;
      end

      a_r11_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set[i] && !clr_mask[i]) |=> flags_q[i]);
      a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[i] && !w1c[i] && !clr_mask[i]) |=> flags_q[i]);
      a_r11_w1c_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c[i] && !set[i]) |=> !flags_q[i]);
      a_r10_group_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_mask[i] |=> !flags_q[i]);
    end
  endgenerate

  assign flags = flags_q;
  assign irq   = |(flags_q & irq_en);
endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair #(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 32,
  parameter int TX_LW    = 5,
  parameter int RX_LW    = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            tx_en,
  input  logic                            rx_en,
  input  logic                            tx_clr,
  input  logic                            rx_clr,
  input  logic [TX_LW-1:0]                tx_level,
  input  logic [RX_LW-1:0]                rx_level,
  input  logic                            tx_dma_en,
  input  logic                            rx_dma_en,
  input  logic [7:0]                      irq_en,
  input  logic [7:0]                      flag_clr,
  input  logic                            bw_valid,
  output logic                            bw_ready,
  input  logic [1:0]                      bw_size,
  input  logic [31:0]                     bw_data,
  output logic                            br_valid,
  input  logic                            br_ready,
  input  logic [1:0]                      br_size,
  output logic [31:0]                     br_data,
  output logic                            st_valid,
  input  logic                            st_ready,
  output logic [31:0]                     st_data,
  input  logic                            sr_valid,
  output logic                            sr_ready,
  input  logic [31:0]                     sr_data,
  output logic [$clog2(TX_DEPTH+1)-1:0]   tx_count,
  output logic [$clog2(RX_DEPTH+1)-1:0]   rx_count,
  output logic [7:0]                      flags,
  output logic                            irq,
  output logic                            tx_dma_req,
  output logic                            rx_dma_req
);
  import sfp_pkg::*;

  localparam int TX_CW = $clog2(TX_DEPTH + 1);
  localparam int RX_CW = $clog2(RX_DEPTH + 1);

  logic [DW-1:0]     tx_in, rx_head;
  logic              tx_ovr, tx_und, rx_ovr, rx_und;
  logic              tx_low, rx_high;
  logic [NFLAGS-1:0] ev, clr_mask;

  assign tx_in = size_fit(bw_data, bw_size);

  sfp_queue #(.DEPTH(TX_DEPTH), .DW(DW)) u_txq (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .clr(tx_clr),
    .in_valid(bw_valid), .in_ready(bw_ready), .in_data(tx_in),
    .out_valid(st_valid), .out_ready(st_ready), .out_data(st_data),
    .count(tx_count), .ovr_ev(tx_ovr), .und_ev(tx_und)
  );

  sfp_queue #(.DEPTH(RX_DEPTH), .DW(DW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .clr(rx_clr),
    .in_valid(sr_valid), .in_ready(sr_ready), .in_data(sr_data),
    .out_valid(br_valid), .out_ready(br_ready), .out_data(rx_head),
    .count(rx_count), .ovr_ev(rx_ovr), .und_ev(rx_und)
  );

  assign br_data = size_fit(rx_head, br_size);

  sfp_level #(.CW(TX_CW), .LW(TX_LW), .ABOVE(1'b0)) u_txlvl (
    .en(tx_en), .dma_en(tx_dma_en), .count(tx_count), .level(tx_level),
    .cond(tx_low), .dma_req(tx_dma_req)
  );

  sfp_level #(.CW(RX_CW), .LW(RX_LW), .ABOVE(1'b1)) u_rxlvl (
    .en(rx_en), .dma_en(rx_dma_en), .count(rx_count), .level(rx_level),
    .cond(rx_high), .dma_req(rx_dma_req)
  );

  always_comb begin
    ev = '0;
    ev[FL_TX_LOW]   = tx_low;
    ev[FL_RX_HIGH]  = rx_high;
    ev[FL_TX_EMPTY] = tx_en && (tx_count == '0);
    ev[FL_RX_FULL]  = rx_en && (rx_count == RX_CW'(RX_DEPTH));
    ev[FL_TX_OVR]   = tx_ovr;
    ev[FL_TX_UND]   = tx_und;
    ev[FL_RX_OVR]   = rx_ovr;
    ev[FL_RX_UND]   = rx_und;
    clr_mask = (tx_clr ? TX_GROUP : '0) | (rx_clr ? RX_GROUP : '0);
  end

  sfp_flags #(.N(NFLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(ev), .w1c(flag_clr), .clr_mask(clr_mask),
    .irq_en(irq_en), .flags(flags), .irq(irq)
  );

  a_r6_underrun_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ready && !st_valid && tx_en && !tx_clr) |=> flags[FL_TX_UND]);
  a_r8_underrun_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (br_ready && !br_valid && rx_en && !rx_clr) |=> flags[FL_RX_UND]);
  a_r7_overrun_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_valid && !sr_ready && rx_en && !rx_clr) |=> flags[FL_RX_OVR]);
endmodule

// File: tb/spi_fifo_pair_bench.sv
module spi_fifo_pair_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 0, rx_en = 0, tx_clr = 0, rx_clr = 0;
  logic [4:0] tx_level = 0;
  logic [5:0] rx_level = 0;
  logic tx_dma_en = 0, rx_dma_en = 0;
  logic [7:0] irq_en = 0, flag_clr = 0;
  logic bw_valid = 0, br_ready = 0, st_ready = 0, sr_valid = 0;
  logic [1:0] bw_size = 2, br_size = 2;
  logic [31:0] bw_data = 0, sr_data = 0;
  logic bw_ready, br_valid, st_valid, sr_ready, irq, tx_dma_req, rx_dma_req;
  logic [31:0] br_data, st_data;
  logic [4:0] tx_count;
  logic [5:0] rx_count;
  logic [7:0] flags;

  always #2 clk = ~clk;

  spi_fifo_pair u_spi_fifo_pair (.*);

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] txq[$];
  logic [31:0] rxq[$];
  logic [7:0] mflags = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] fit(input logic [31:0] d, input logic [1:0] sz);
    if (sz == 2'd0) return d & 32'h0000_00ff;
    if (sz == 2'd1) return d & 32'h0000_ffff;
    return d;
  endfunction

  // check current outputs against the model, then advance model and clock
  task automatic cyc();
    bit trdy, tv, rrdy, rv;
    logic [7:0] ev, nf;
    #1;
    trdy = tx_en && txq.size() < 16;
    tv   = tx_en && txq.size() > 0;
    rrdy = rx_en && rxq.size() < 32;
    rv   = rx_en && rxq.size() > 0;
    chk("R2 tx_count", 32'(tx_count), 32'(txq.size()));
    chk("R2 rx_count", 32'(rx_count), 32'(rxq.size()));
    chk("R2 bw_ready", 32'(bw_ready), 32'(trdy));
    chk("R2 st_valid", 32'(st_valid), 32'(tv));
    chk("R2 sr_ready", 32'(sr_ready), 32'(rrdy));
    chk("R2 br_valid", 32'(br_valid), 32'(rv));
    chk("R1 R6 st_data", st_data, tv ? txq[0] : 32'h0);
    chk("R1 R8 br_data", br_data, rv ? fit(rxq[0], br_size) : 32'h0);
    chk("R3 flag0", 32'(flags[0]), 32'(mflags[0]));
    chk("R4 flag1", 32'(flags[1]), 32'(mflags[1]));
    chk("R9 flag2", 32'(flags[2]), 32'(mflags[2]));
    chk("R9 flag3", 32'(flags[3]), 32'(mflags[3]));
    chk("R5 flag4", 32'(flags[4]), 32'(mflags[4]));
    chk("R6 flag5", 32'(flags[5]), 32'(mflags[5]));
    chk("R7 flag6", 32'(flags[6]), 32'(mflags[6]));
    chk("R8 flag7", 32'(flags[7]), 32'(mflags[7]));
    chk("R12 irq", 32'(irq), 32'(|(mflags & irq_en)));
    chk("R3 R13 tx_dma_req", 32'(tx_dma_req), 32'(tx_dma_en && tx_en && txq.size() < int'(tx_level)));
    chk("R4 R13 rx_dma_req", 32'(rx_dma_req), 32'(rx_dma_en && rx_en && rxq.size() > int'(rx_level)));
    ev = 0;
    ev[0] = tx_en && txq.size() < int'(tx_level);
    ev[1] = rx_en && rxq.size() > int'(rx_level);
    ev[2] = tx_en && txq.size() == 0;
    ev[3] = rx_en && rxq.size() == 32;
    ev[4] = tx_en && bw_valid && !trdy;
    ev[5] = tx_en && st_ready && !tv;
    ev[6] = rx_en && sr_valid && !rrdy;
    ev[7] = rx_en && br_ready && !rv;
    nf = (mflags & ~flag_clr) | ev;
    if (tx_clr) nf = nf & ~8'h35;
    if (rx_clr) nf = nf & ~8'hCA;
    mflags = nf;
    if (tx_clr) txq.delete();
    else begin
      if (st_ready && tv) void'(txq.pop_front());
      if (bw_valid && trdy) txq.push_back(fit(bw_data, bw_size));
    end
    if (rx_clr) rxq.delete();
    else begin
      if (br_ready && rv) void'(rxq.pop_front());
      if (sr_valid && rrdy) rxq.push_back(sr_data);
    end
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    tx_clr = 0; rx_clr = 0; flag_clr = 0;
    bw_valid = 0; br_ready = 0; st_ready = 0; sr_valid = 0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk("R2 reset tx_count", 32'(tx_count), 0);
    chk("R2 reset rx_count", 32'(rx_count), 0);
    chk("R11 reset flags", 32'(flags), 0);
    rst_n = 1;
    @(posedge clk); #1;
    cyc();

    // disabled queues ignore traffic (R13)
    bw_valid = 1; bw_data = 32'h1111_2222; st_ready = 1; sr_valid = 1; br_ready = 1;
    repeat (3) cyc();
    chk("R13 disabled count", 32'(tx_count), 0);
    chk("R13 disabled flags", 32'(flags), 0);
    quiet();

    tx_en = 1; rx_en = 1; tx_level = 4; rx_level = 2;
    repeat (2) cyc();
    // w1c collides with a persisting event: event wins (R11)
    flag_clr = 8'hff; cyc(); quiet(); cyc();
    chk("R11 event wins flag2", 32'(flags[2]), 1);

    // sizes (R1)
    bw_valid = 1; bw_size = 0; bw_data = 32'hAABB_CCDD; cyc();
    bw_size = 1; cyc();
    bw_size = 2; cyc();
    bw_size = 3; bw_data = 32'h0102_0304; cyc();
    quiet();
    st_ready = 1; cyc();
    chk("R1 halfword", st_data, 32'h0000_CCDD);
    quiet(); cyc();
    // fill transmit past full (R5)
    bw_size = 2;
    for (int i = 0; i < 15; i++) begin
      bw_valid = 1; bw_data = 32'hC000_0000 + i; cyc();
    end
    quiet(); cyc();
    chk("R5 count at full", 32'(tx_count), 16);
    chk("R5 overrun flag", 32'(flags[4]), 1);
    // drain past empty (R6)
    st_ready = 1;
    repeat (17) cyc();
    quiet(); cyc();
    chk("R6 underrun flag", 32'(flags[5]), 1);

    // fill receive past full (R7), read with sizes, past empty (R8)
    for (int i = 0; i < 34; i++) begin
      sr_valid = 1; sr_data = 32'h5A00_0000 + 32'(i * 257); cyc();
    end
    quiet(); cyc();
    chk("R9 rx full flag", 32'(flags[3]), 1);
    chk("R7 rx overrun flag", 32'(flags[6]), 1);
    for (int i = 0; i < 34; i++) begin
      br_ready = 1; br_size = 2'(i % 4); cyc();
    end
    quiet(); cyc();
    chk("R8 rx underrun flag", 32'(flags[7]), 1);

    // clear with simultaneous push (R10)
    bw_valid = 1; bw_data = 32'h77; cyc(); cyc();
    tx_clr = 1; cyc(); quiet(); #0;
    chk("R10 clear empties", 32'(tx_count), 0);
    chk("R10 clear flags", 32'(flags & 8'h35), 0);
    cyc();

    // w1c without events (R11), irq (R12)
    tx_en = 0; rx_en = 0; cyc();
    irq_en = 8'h80; cyc();
    chk("R12 irq from flag7", 32'(irq), 32'(flags[7]));
    flag_clr = 8'hff; cyc(); quiet(); cyc();
    chk("R11 w1c clears", 32'(flags), 0);
    chk("R12 irq quiet", 32'(irq), 0);

    // DMA drop (R13)
    tx_en = 1; tx_level = 8; tx_dma_en = 1; cyc();
    chk("R3 dma high", 32'(tx_dma_req), 1);
    tx_dma_en = 0; #1;
    chk("R13 dma drops", 32'(tx_dma_req), 0);
    cyc();

    // constrained random phases
    rx_en = 1;
    for (int ph = 0; ph < 20; ph++) begin
      int pw, pr, ps, pb;
      pw = ($urandom % 3) * 40 + 10; pr = ($urandom % 3) * 40 + 10;
      ps = ($urandom % 3) * 40 + 10; pb = ($urandom % 3) * 40 + 10;
      tx_level = 5'($urandom % 18); rx_level = 6'($urandom % 34);
      irq_en = 8'($urandom); tx_dma_en = 1'($urandom); rx_dma_en = 1'($urandom);
      for (int c = 0; c < 250; c++) begin
        tx_en = ($urandom % 64) != 0;
        rx_en = ($urandom % 64) != 0;
        tx_clr = ($urandom % 128) == 0;
        rx_clr = ($urandom % 128) == 0;
        flag_clr = (($urandom % 8) == 0) ? 8'($urandom) : 8'h0;
        bw_valid = ($urandom % 100) < pw; bw_size = 2'($urandom); bw_data = $urandom;
        st_ready = ($urandom % 100) < pr;
        sr_valid = ($urandom % 100) < ps; sr_data = $urandom;
        br_ready = ($urandom % 100) < pb; br_size = 2'($urandom);
        cyc();
      end
    end
    quiet(); cyc();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule